// File: doc/BRIEF.md
# Comma-aligned 10b/20b word deserializer

This block turns a recovered serial bit stream into parallel words. Bits arrive one per clock in which the bit-enable input is high. A static width select chooses 10-bit or 20-bit words. Each completed word is presented for one cycle with a valid strobe. The first bit received in a word always lands in the word's most significant bit.

With framing enabled, or with the test-mode input active, the block watches the stream for the positive-disparity K28.5 comma at every bit offset. When it sees the comma, it moves its word boundary so that the comma opens a word. In 20-bit mode this places the comma in the upper character. A sync flag, registered together with each word, marks words that carry the comma. With framing disabled and test mode off, bits are grouped into words with no alignment. Dropping framing enable, or changing the width select, discards the boundary currently held and restarts word collection.

Top module: `comma_deser`

## Requirements
- R1: While the synchronous active-low reset is low, and in the first cycle after it is released, `word_vld`, `sync_out` and `word_out` are all zero.
- R2: With framing and test mode both off, a word is produced after every 10 accepted bits (`wide_sel`=0) or every 20 accepted bits (`wide_sel`=1). The first accepted bit of a word appears at bit 9 or bit 19 respectively, later bits follow toward bit 0, bits 19:10 are zero in 10-bit mode, and commas in the data cause no realignment.
- R3: A cycle with `bit_en` low accepts no bit and never raises `word_vld` in the following cycle.
- R4: When detection is on, the 10-bit pattern 0011111010 (leftmost bit received first) completing at any bit offset makes that pattern the first character of a word. In 10-bit mode that word is output in the cycle after the pattern's last bit, and any partial word collected before it is dropped.
- R5: In 20-bit mode a detected comma always becomes bits 19:10 of the word. A comma completing in the lower character position restarts collection from the comma, and the word it would have ended is not output.
- R6: A comma that completes exactly on the current word boundary leaves the word cadence unchanged: no word is dropped, shortened or repeated.
- R7: `sync_out` is updated with every valid word. It is high while the held word carries the comma pattern in a character slot (bits 9:0, or bits 19:10 in 20-bit mode) and low otherwise.
- R8: With `test_mode` high, comma detection and realignment work even while `frame_en` is low.
- R9: In a cycle where `frame_en` falls, the boundary held is discarded. Collection restarts from zero, and that cycle's bit is not counted.
- R10: In a cycle where `wide_sel` changes, collection restarts from zero and that cycle's bit is not counted.
- R11: `word_vld` is a single-cycle strobe, and `word_out` changes only in a cycle where `word_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` as one received bit |
| bit_in | input | 1 | Serial data bit |
| wide_sel | input | 1 | 0: 10-bit words, 1: 20-bit words |
| frame_en | input | 1 | Enables comma alignment |
| test_mode | input | 1 | Forces comma detection on |
| word_out | output | 20 | Parallel word, first received bit in the MSB |
| word_vld | output | 1 | One-cycle strobe for a new word |
| sync_out | output | 1 | Held word contains the comma |

## Verification
A wrong bit count shows up at the first word after it goes wrong: `word_vld` fires a cycle early or late, and `word_out` carries bits shifted by one position. A missed or false comma detection shows up at the next valid word, as a comma outside bits 19:10 or a misplaced `sync_out`, within 20 accepted bits. A reference model that keeps bit queues is compared with the outputs on every clock, so the first divergent cycle is reported. Stimulus covers commas at unaligned offsets, in the lower slot, on the boundary, and around configuration changes.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
   localparam int CHAR_W = 10;
   // leftmost bit is the first one received
   localparam logic [CHAR_W-1:0] COMMA_P = 10'b0011111010;

   typedef enum logic [1:0] {
      STEP_IDLE    = 2'd0,
      STEP_BIT     = 2'd1,
      STEP_EMIT    = 2'd2,
      STEP_RESTART = 2'd3
   } step_e;
endpackage

// File: rtl/cd_shift_window.sv
module cd_shift_window
   import comma_deser_pkg::*;
#(
   parameter int C_W   = CHAR_W,
   parameter int SLOTS = 2,
   localparam int W_W  = C_W * SLOTS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_en,
   input  logic           bit_in,
   output logic [W_W-1:0] win_nx,
   output logic           comma_hit
);
   logic [W_W-1:0] sr_q;

   if (W_W < 2) begin : g_bad_width
      $error("cd_shift_window: window too narrow");
   end

   assign win_nx    = {sr_q[W_W-2:0], bit_in};
   assign comma_hit = bit_en && (win_nx[C_W-1:0] == COMMA_P);

   always_ff @(posedge clk) begin
      if (!rst_n)      sr_q <= '0;
      else if (bit_en) sr_q <= win_nx;
   end
endmodule

// File: rtl/cd_word_counter.sv
module cd_word_counter
   import comma_deser_pkg::*;
#(
   parameter int C_W   = CHAR_W,
   parameter int SLOTS = 2,
   localparam int W_W  = C_W * SLOTS,
   localparam int CNT_W = $clog2(W_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic comma_hit,
   input  logic detect_on,
   input  logic wide_sel,
   input  logic frame_en,
   output logic emit
);
   logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_inc, limit;
   logic             wide_q, frame_q, restart, wide_now;
   step_e            step;

   if (SLOTS != 1 && SLOTS != 2) begin : g_bad_slots
      $error("cd_word_counter: SLOTS must be 1 or 2");
   end

   if (SLOTS == 1) begin : g_narrow
      assign wide_now = 1'b0;
   end else begin : g_dual
      assign wide_now = wide_sel;
   end

   assign limit   = wide_now ? CNT_W'(W_W) : CNT_W'(C_W);
   assign cnt_inc = cnt_q + 1'b1;
   assign restart = (wide_sel != wide_q) || (frame_q && !frame_en);

   always_comb begin
      step   = STEP_IDLE;
      cnt_nx = cnt_q;
      if (restart) begin
         step   = STEP_RESTART;
         cnt_nx = '0;
      end else if (bit_en) begin
         if (comma_hit && detect_on) begin
            if (wide_now) begin
               step   = STEP_BIT;
               cnt_nx = CNT_W'(C_W);
            end else begin
               step   = STEP_EMIT;
               cnt_nx = '0;
            end
         end else if (cnt_inc == limit) begin
            step   = STEP_EMIT;
            cnt_nx = '0;
         end else begin
            step   = STEP_BIT;
            cnt_nx = cnt_inc;
         end
      end
   end

   assign emit = (step == STEP_EMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         wide_q  <= wide_sel;
         frame_q <= frame_en;
      end else begin
         cnt_q   <= cnt_nx;
         wide_q  <= wide_sel;
         frame_q <= frame_en;
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(W_W));

   // R3
   idle_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |-> !emit);

   // R9
   fall_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_en) |=> (cnt_q == '0));
endmodule

// File: rtl/cd_out_reg.sv
module cd_out_reg
   import comma_deser_pkg::*;
#(
   parameter int C_W   = CHAR_W,
   parameter int SLOTS = 2,
   localparam int W_W  = C_W * SLOTS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           emit,
   input  logic           wide_sel,
   input  logic [W_W-1:0] win_nx,
   output logic [W_W-1:0] word_out,
   output logic           word_vld,
   output logic           sync_out
);
   logic [W_W-1:0]   word_nx;
   logic [SLOTS-1:0] slot_hit;

   assign word_nx = wide_sel ? win_nx : W_W'(win_nx[C_W-1:0]);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slot_hit[s] = (word_nx[s*C_W +: C_W] == COMMA_P);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out <= '0;
         word_vld <= 1'b0;
         sync_out <= 1'b0;
      end else begin
         word_vld <= emit;
         if (emit) begin
            word_out <= word_nx;
            sync_out <= |slot_hit;
         end
      end
   end

   // R7
   sync_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_out |-> (word_out[C_W-1:0] == COMMA_P || word_out[W_W-1 -: C_W] == COMMA_P));

   // R11
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out));
endmodule

// File: rtl/comma_deser.sv
module comma_deser
   import comma_deser_pkg::*;
#(
   parameter int C_W   = CHAR_W,
   parameter int SLOTS = 2,
   localparam int W_W  = C_W * SLOTS
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_en,
   input  logic           bit_in,
   input  logic           wide_sel,
   input  logic           frame_en,
   input  logic           test_mode,
   output logic [W_W-1:0] word_out,
   output logic           word_vld,
   output logic           sync_out
);
   logic [W_W-1:0] win_nx;
   logic           comma_hit, emit, detect_on;

   if (C_W != $bits(COMMA_P)) begin : g_bad_char
      $error("comma_deser: character width must match the comma pattern");
   end

   // R8: test mode keeps detection alive
   assign detect_on = frame_en | test_mode;

   cd_shift_window #(.C_W(C_W), .SLOTS(SLOTS)) win_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .win_nx(win_nx), .comma_hit(comma_hit));

   cd_word_counter #(.C_W(C_W), .SLOTS(SLOTS)) cnt_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .comma_hit(comma_hit),
      .detect_on(detect_on), .wide_sel(wide_sel), .frame_en(frame_en),
      .emit(emit));

   cd_out_reg #(.C_W(C_W), .SLOTS(SLOTS)) out_i (
      .clk(clk), .rst_n(rst_n), .emit(emit), .wide_sel(wide_sel),
      .win_nx(win_nx), .word_out(word_out), .word_vld(word_vld),
      .sync_out(sync_out));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (!word_vld && !sync_out && word_out == '0));
endmodule

// File: tb/comma_deser_tb_top.sv
module comma_deser_tb_top;
   localparam logic [9:0] KPAT = 10'b0011111010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0, bit_in = 1'b0;
   logic        wide_sel = 1'b0, frame_en = 1'b0, test_mode = 1'b0;
   logic [19:0] word_out;
   logic        word_vld, sync_out;

   int    n_chk = 0, n_bad = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   comma_deser dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .wide_sel(wide_sel), .frame_en(frame_en), .test_mode(test_mode),
      .word_out(word_out), .word_vld(word_vld), .sync_out(sync_out));

   // reference model: bit queues
   bit          q[$];
   bit          h[$];
   logic [19:0] m_word = '0;
   logic        m_vld = 1'b0, m_sync = 1'b0;
   logic        m_wide = 1'b0, m_fe = 1'b0;

   function automatic logic [9:0] last10();
      logic [9:0] v = '0;
      for (int i = 0; i < 10; i++) v[9-i] = h[h.size()-10+i];
      return v;
   endfunction

   task automatic m_emit();
      logic [19:0] w = '0;
      for (int i = 0; i < q.size(); i++) w[q.size()-1-i] = q[i];
      m_word = w;
      m_vld  = 1'b1;
      m_sync = (w[9:0] == KPAT) || (wide_sel && w[19:10] == KPAT);
      q.delete();
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); h.delete();
         for (int i = 0; i < 10; i++) h.push_back(1'b0);
         m_vld = 0; m_word = '0; m_sync = 0;
         m_wide = wide_sel; m_fe = frame_en;
      end else begin
         bit restart;
         m_vld   = 1'b0;
         restart = (wide_sel != m_wide) || (m_fe && !frame_en);
         if (bit_en) begin
            h.push_back(bit_in);
            if (h.size() > 10) void'(h.pop_front());
         end
         if (restart) q.delete();
         else if (bit_en) begin
            q.push_back(bit_in);
            if ((frame_en || test_mode) && last10() == KPAT) begin
               q.delete();
               for (int i = 0; i < 10; i++) q.push_back(h[i]);
               if (!wide_sel) m_emit();
            end else if (q.size() == (wide_sel ? 20 : 10)) m_emit();
         end
         m_wide = wide_sel; m_fe = frame_en;
      end
   end

   task automatic chk(input string what, input logic [19:0] act, input logic [19:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison; R11 strobe width and hold covered by the vld/word compare
   always @(negedge clk) begin
      chk("word_vld", {19'd0, word_vld}, {19'd0, m_vld});
      chk("word_out", word_out, m_word);
      chk("sync_out", {19'd0, sync_out}, {19'd0, m_sync});
   end

   task automatic send(input logic b, input logic en);
      @(negedge clk);
      bit_en = en; bit_in = b;
   endtask

   task automatic send_char(input logic [9:0] c);
      for (int i = 9; i >= 0; i--) send(c[i], 1'b1);
   endtask

   task automatic send_rand(input int n, input int gap_pct);
      for (int i = 0; i < n; i++) begin
         if ($urandom_range(99) < gap_pct) send(1'b0, 1'b0);
         send(1'($urandom_range(1)), 1'b1);
      end
   endtask

   task automatic set_cfg(input logic w, input logic f, input logic t);
      @(negedge clk);
      bit_en = 1'b0; wide_sel = w; frame_en = f; test_mode = t;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int cnt_v;
      // R1 reset state
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset word", {word_out[19:1], word_vld ^ sync_out}, 20'd0);

      cur_req = "R2"; set_cfg(0, 0, 0);
      send_rand(60, 0);
      send_char(KPAT); send_rand(13, 0);
      cur_req = "R3"; send_rand(80, 50);
      cur_req = "R2"; set_cfg(1, 0, 0);
      send_rand(7, 0); send_char(KPAT); send_rand(63, 20);

      cur_req = "R4"; set_cfg(0, 1, 0);
      send_rand(3, 0); send_char(KPAT); send_rand(34, 0);
      send_char(KPAT); send_rand(25, 30);
      cur_req = "R7";
      send_char(10'h2AA); send_char(KPAT); send_char(10'h155); send_char(KPAT);

      cur_req = "R5"; set_cfg(1, 1, 0);
      send_rand(7, 0); send_char(KPAT); send_rand(10, 0); send_char(KPAT);
      send_rand(30, 0);

      cur_req = "R6";
      cnt_v = 0;
      for (int k = 0; k < 6; k++) begin
         send_char(KPAT); send_char(10'h1C3);
         if (word_vld) cnt_v++;
      end
      send_rand(20, 0);

      cur_req = "R8"; set_cfg(0, 0, 1);
      send_rand(5, 0); send_char(KPAT); send_rand(25, 0);

      cur_req = "R9"; set_cfg(1, 1, 0);
      send_char(KPAT); send_rand(5, 0);
      set_cfg(1, 0, 0);
      send_rand(45, 0);

      cur_req = "R10";
      send_rand(13, 0); set_cfg(0, 0, 0); send_rand(35, 0);
      send_rand(4, 0);  set_cfg(1, 0, 0); send_rand(45, 0);

      cur_req = "R11";
      for (int k = 0; k < 120; k++) begin
         if ($urandom_range(9) == 0) set_cfg(1'($urandom_range(1)), 1'($urandom_range(1)), 1'b0);
         if ($urandom_range(3) == 0) send_char(KPAT);
         send_rand(int'($urandom_range(25)), 25);
      end
      send_rand(40, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule